// File: doc/BRIEF.md
# Passive LCD Scan Timing Controller

This block sequences the scan of a passive (STN-style) LCD panel that takes pixel data four bits at a time. A qualifying clock enable marks each video-rate transfer. On each such tick the block advances a transfer counter within the current line and a line counter within the current frame. It drives a line pulse after the last transfer of every line and a frame pulse for the whole first line of every frame. It also drives an alternating-drive signal that keeps the liquid crystal free of DC bias, and a one-cycle strobe that tells the pixel fetch engine to rewind its address to the frame buffer base.

The scan geometry comes from the panel size in pixels and the colour mode. In 8-bit colour on a single panel, each group of 8 pixels needs 3 nibble transfers, one for each of red, green and blue. Every other mode moves 4 pixels per transfer. In split-panel mode the two halves scan in parallel, so a frame holds half as many lines. The block also reports the video-rate divider value that matches the computed geometry.

Video is controlled by an enable bit and a display-on bit. A freeze request lets the current frame finish and then stops the scan cleanly. When freeze is released with enable still set, scanning resumes from the top of a new frame. The pixel nibble presented by the fetch engine is passed through, inverted when the invert bit is set.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: The transfers per line are (width/8)*3 when the depth is 2'b11 (8-bit colour) and split is clear, and width/4 in every other case. The output `rate_div` equals this transfer count, that is, the horizontal last index plus one.
- R2: A frame holds `panel_height` lines, or `panel_height/2` lines when split is set. This shows as that many line pulse rising edges from one frame start to the next.
- R3: `line_pulse` rises on the tick that completes the last transfer of a line. It stays high until the next tick and does not change between ticks.
- R4: `frame_pulse` is high from a frame's start through the tick that ends its first line, and low for the rest of the frame.
- R5: `dma_restart` is high for exactly one clock at each frame start: on the first start after enabling and at every frame wrap. `frame_pulse` is high in that same clock.
- R6: With `ctl_alt_line` clear, `alt_drive` toggles once per frame, at the frame wrap. With it set, it toggles at the end of every line. It starts at 0.
- R7: While `ctl_freeze` is set, scanning continues to the end of the current frame and then stops with all outputs low. No new frame starts while freeze is held. Clearing freeze with enable and display-on set starts a new frame (with `dma_restart` and `frame_pulse` high) one clock later.
- R8: While scanning, `vdata` is the previous clock's `pix_in`, bitwise inverted when `ctl_invert` is set.
- R9: When `ctl_disp_on` or `ctl_enable` is clear, every output except `rate_div` is low from the next clock on. Out of reset, all outputs are low.
- R10: The depth codes 2'b00 (monochrome), 2'b01 (2-bit grey) and 2'b10 (4-bit grey) all use the width/4 transfer count. Only 2'b11 selects the colour count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_tick | input | 1 | Video-rate transfer enable |
| ctl_enable | input | 1 | Video logic enable |
| ctl_disp_on | input | 1 | Display power on |
| ctl_split | input | 1 | Split-panel mode |
| ctl_depth | input | 2 | Depth code (00 mono, 01 2-bit grey, 10 4-bit grey, 11 8-bit colour) |
| ctl_invert | input | 1 | Invert the data nibble |
| ctl_freeze | input | 1 | Stop at the end of the current frame |
| ctl_alt_line | input | 1 | Toggle alternating drive per line instead of per frame |
| panel_width | input | WW | Panel width in pixels |
| panel_height | input | HW | Panel height in lines |
| pix_in | input | DATA_W | Pixel nibble from the fetch engine |
| vdata | output | DATA_W | Data nibble to the panel |
| line_pulse | output | 1 | Line latch pulse |
| frame_pulse | output | 1 | First-line frame marker |
| alt_drive | output | 1 | Alternating-drive signal |
| dma_restart | output | 1 | Frame-start address rewind strobe |
| rate_div | output | WW | Video-rate divider value |

## Verification
The bench goes after the geometry corners: colour mode with and without split, and each grey or mono depth code. A wrong formula would put a wrong `rate_div` on the port and change the number of line pulses per frame. It places a freeze request in the middle of a frame. A design that stopped at once would cut the frame short, and one that ignored the request would produce another frame-start strobe; both differ from the reference model. It also releases freeze, drops display-on and switches the alternating-drive mode. A design that restarted mid-frame, left any output driven while the display was off, or toggled the drive signal at the wrong boundary would miss the per-cycle comparison.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        DEPTH_MONO   = 2'b00,
        DEPTH_GREY2  = 2'b01,
        DEPTH_GREY4  = 2'b10,
        DEPTH_COLOR8 = 2'b11
    } depth_e;

    // pixels moved per nibble transfer in the packed modes
    localparam int PIX_PER_XFER     = 4;
    // colour mode: 8 pixels need 3 nibble transfers (R, G, B)
    localparam int COLOR_GROUP_PIX  = 8;
    localparam int COLOR_GROUP_XFER = 3;

endpackage

// File: rtl/lcd_scan_geom.sv
module lcd_scan_geom
    import lcd_scan_pkg::*;
#(
    parameter int WW = 10,
    parameter int HW = 9
) (
    input  logic [1:0]    depth,
    input  logic          split,
    input  logic [WW-1:0] width,
    input  logic [HW-1:0] height,
    output logic [WW-1:0] h_last,
    output logic [HW-1:0] v_last,
    output logic [WW-1:0] rate
);
    localparam int GRP_SH = $clog2(COLOR_GROUP_PIX);
    localparam int XFR_SH = $clog2(PIX_PER_XFER);

    logic          color_full;
    logic [WW-1:0] xfers;

    always_comb begin
        color_full = (depth_e'(depth) == DEPTH_COLOR8) && !split;
        if (color_full)
            xfers = WW'((width >> GRP_SH) * COLOR_GROUP_XFER);
        else
            xfers = width >> XFR_SH;
        h_last = xfers - 1'b1;
        rate   = h_last + 1'b1;
        v_last = (split ? (height >> 1) : height) - 1'b1;
    end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
    parameter int HCW = 10,
    parameter int VCW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           go,
    input  logic           freeze,
    input  logic           alt_line,
    input  logic [HCW-1:0] h_last,
    input  logic [VCW-1:0] v_last,
    output logic           run_d_o,
    output logic           run_o,
    output logic           line_pulse,
    output logic           frame_pulse,
    output logic           alt_drive,
    output logic           dma_restart
);
    typedef struct packed {
        logic           run;
        logic [HCW-1:0] h;
        logic [VCW-1:0] v;
        logic           lp;
        logic           fp;
        logic           alt;
        logic           dma;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.dma = 1'b0;
        if (!go) begin
            seq_d = '0;
        end else if (!seq_q.run) begin
            if (!freeze) begin
                seq_d.run = 1'b1;
                seq_d.h   = '0;
                seq_d.v   = '0;
                seq_d.lp  = 1'b0;
                seq_d.fp  = 1'b1;
                seq_d.dma = 1'b1;
            end
        end else if (tick) begin
            seq_d.lp = (seq_q.h >= h_last);
            if (seq_q.h >= h_last) begin
                seq_d.h = '0;
                if (alt_line)
                    seq_d.alt = ~seq_q.alt;
                if (seq_q.v >= v_last) begin
                    seq_d.v = '0;
                    if (freeze) begin
                        seq_d = '0;
                    end else begin
                        seq_d.fp  = 1'b1;
                        seq_d.dma = 1'b1;
                        if (!alt_line)
                            seq_d.alt = ~seq_q.alt;
                    end
                end else begin
                    seq_d.v  = seq_q.v + 1'b1;
                    seq_d.fp = 1'b0;
                end
            end else begin
                seq_d.h = seq_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seq_q <= '0;
        else
            seq_q <= seq_d;
    end

    assign run_d_o     = seq_d.run;
    assign run_o       = seq_q.run;
    assign line_pulse  = seq_q.lp;
    assign frame_pulse = seq_q.fp;
    assign alt_drive   = seq_q.alt;
    assign dma_restart = seq_q.dma;
endmodule

// File: rtl/lcd_scan_pix.sv
module lcd_scan_pix #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_next,
    input  logic              invert,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] vdata
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        if (run_next)
            data_d = pix_in ^ {DATA_W{invert}};
        else
            data_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else
            data_q <= data_d;
    end

    assign vdata = data_q;
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
    parameter int WW     = 10,
    parameter int HW     = 9,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vid_tick,
    input  logic              ctl_enable,
    input  logic              ctl_disp_on,
    input  logic              ctl_split,
    input  logic [1:0]        ctl_depth,
    input  logic              ctl_invert,
    input  logic              ctl_freeze,
    input  logic              ctl_alt_line,
    input  logic [WW-1:0]     panel_width,
    input  logic [HW-1:0]     panel_height,
    input  logic [DATA_W-1:0] pix_in,
    output logic [DATA_W-1:0] vdata,
    output logic              line_pulse,
    output logic              frame_pulse,
    output logic              alt_drive,
    output logic              dma_restart,
    output logic [WW-1:0]     rate_div
);
    logic [WW-1:0] h_last;
    logic [HW-1:0] v_last;
    logic          scan_go;
    logic          scan_run_d;
    logic          scan_run;

    assign scan_go = ctl_enable && ctl_disp_on;

    lcd_scan_geom #(.WW(WW), .HW(HW)) u_geom (
        .depth  (ctl_depth),
        .split  (ctl_split),
        .width  (panel_width),
        .height (panel_height),
        .h_last (h_last),
        .v_last (v_last),
        .rate   (rate_div)
    );

    lcd_scan_seq #(.HCW(WW), .VCW(HW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (vid_tick),
        .go          (scan_go),
        .freeze      (ctl_freeze),
        .alt_line    (ctl_alt_line),
        .h_last      (h_last),
        .v_last      (v_last),
        .run_d_o     (scan_run_d),
        .run_o       (scan_run),
        .line_pulse  (line_pulse),
        .frame_pulse (frame_pulse),
        .alt_drive   (alt_drive),
        .dma_restart (dma_restart)
    );

    lcd_scan_pix #(.DATA_W(DATA_W)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_next (scan_run_d),
        .invert   (ctl_invert),
        .pix_in   (pix_in),
        .vdata    (vdata)
    );
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vid_tick,
    input logic          ctl_enable,
    input logic          ctl_disp_on,
    input logic          ctl_freeze,
    input logic          ctl_alt_line,
    input logic          run,
    input logic [DW-1:0] vdata,
    input logic          line_pulse,
    input logic          frame_pulse,
    input logic          alt_drive,
    input logic          dma_restart
);
    logic go;
    assign go = ctl_enable && ctl_disp_on;

    // R9: display off or disabled silences every output next clock
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (vdata == '0 && !line_pulse && !frame_pulse && !alt_drive && !dma_restart));

    // R5: a frame-start strobe always lies inside the first line
    p_dma_first_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_restart |-> frame_pulse);

    // R3: line pulse only moves on a tick while scanning
    p_lp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && go && !vid_tick) |=> $stable(line_pulse));

    // R7: no frame starts while freeze is held from an idle state
    p_freeze_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && ctl_freeze) |=> !dma_restart);

    // R6: in per-frame mode the drive flips only at a frame start or a stop
    p_alt_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && go && !ctl_alt_line && !vid_tick) |=> $stable(alt_drive));
endmodule

bind lcd_scan_ctrl lcd_scan_chk #(.DW(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vid_tick     (vid_tick),
    .ctl_enable   (ctl_enable),
    .ctl_disp_on  (ctl_disp_on),
    .ctl_freeze   (ctl_freeze),
    .ctl_alt_line (ctl_alt_line),
    .run          (scan_run),
    .vdata        (vdata),
    .line_pulse   (line_pulse),
    .frame_pulse  (frame_pulse),
    .alt_drive    (alt_drive),
    .dma_restart  (dma_restart)
);

// File: tb/lcd_scan_ctrl_test.sv
module lcd_scan_ctrl_test;
    localparam int WW = 10;
    localparam int HW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vid_tick = 1'b0;
    logic          ctl_enable = 1'b0, ctl_disp_on = 1'b0, ctl_split = 1'b0;
    logic [1:0]    ctl_depth = 2'b11;
    logic          ctl_invert = 1'b0, ctl_freeze = 1'b0, ctl_alt_line = 1'b0;
    logic [WW-1:0] panel_width = 10'd16;
    logic [HW-1:0] panel_height = 9'd6;
    logic [3:0]    pix_in = 4'h0;
    logic [3:0]    vdata;
    logic          line_pulse, frame_pulse, alt_drive, dma_restart;
    logic [WW-1:0] rate_div;

    int nchk = 0, nfail = 0;
    bit done = 0;
    bit fix_pix = 0;
    logic [3:0] fix_val = 4'h0;
    int cyc = 0;

    always #2 clk = ~clk;

    lcd_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .vid_tick(vid_tick), .ctl_enable(ctl_enable),
        .ctl_disp_on(ctl_disp_on), .ctl_split(ctl_split), .ctl_depth(ctl_depth),
        .ctl_invert(ctl_invert), .ctl_freeze(ctl_freeze), .ctl_alt_line(ctl_alt_line),
        .panel_width(panel_width), .panel_height(panel_height), .pix_in(pix_in),
        .vdata(vdata), .line_pulse(line_pulse), .frame_pulse(frame_pulse),
        .alt_drive(alt_drive), .dma_restart(dma_restart), .rate_div(rate_div)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // tick and pixel driver, changes just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        vid_tick <= (cyc % 3) != 2;
        pix_in   <= fix_pix ? fix_val : 4'((cyc * 7) ^ (cyc >> 2));
    end

    // behavioural reference model
    bit m_run, m_lp, m_fp, m_alt, m_dma;
    int m_h, m_v;
    logic [3:0] m_vd;

    function automatic int exp_hlast();
        if (ctl_depth == 2'b11 && !ctl_split) return (int'(panel_width) / 8) * 3 - 1;
        return int'(panel_width) / 4 - 1;
    endfunction

    function automatic int exp_vlast();
        return (ctl_split ? int'(panel_height) / 2 : int'(panel_height)) - 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_lp = 0; m_fp = 0; m_alt = 0; m_dma = 0; m_h = 0; m_v = 0; m_vd = 0;
        end else begin
            int hl, vl;
            hl = exp_hlast();
            vl = exp_vlast();
            m_dma = 0;
            if (!(ctl_enable && ctl_disp_on)) begin
                m_run = 0; m_lp = 0; m_fp = 0; m_alt = 0; m_h = 0; m_v = 0;
            end else if (!m_run) begin
                if (!ctl_freeze) begin
                    m_run = 1; m_h = 0; m_v = 0; m_dma = 1; m_fp = 1; m_lp = 0;
                end
            end else if (vid_tick) begin
                m_lp = (m_h >= hl);
                if (m_h >= hl) begin
                    m_h = 0;
                    if (ctl_alt_line) m_alt = !m_alt;
                    if (m_v >= vl) begin
                        m_v = 0;
                        if (ctl_freeze) begin
                            m_run = 0; m_lp = 0; m_fp = 0; m_alt = 0;
                        end else begin
                            m_dma = 1; m_fp = 1;
                            if (!ctl_alt_line) m_alt = !m_alt;
                        end
                    end else begin
                        m_v++; m_fp = 0;
                    end
                end else begin
                    m_h++;
                end
            end
            m_vd = m_run ? (pix_in ^ {4{ctl_invert}}) : 4'h0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] got, exp;
            got = {vdata, line_pulse, frame_pulse, alt_drive, dma_restart};
            exp = {m_vd, m_lp, m_fp, m_alt, m_dma};
            chk(got == exp, "model compare R3 R4 R5 R6 R7 R8 R9", int'(got), int'(exp));
        end
    end

    task automatic wait_dma();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (dma_restart) return;
        end
        chk(0, "no frame start seen R5", 0, 1);
    endtask

    // after a frame start, count line pulse rises up to the next start
    task automatic count_lines(output int lines, output bit alt0, output bit alt1, output int alt_flips);
        bit prev_lp, prev_alt;
        lines = 0; alt_flips = 0;
        alt0 = alt_drive;
        prev_lp = line_pulse;
        prev_alt = alt_drive;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (line_pulse && !prev_lp) lines++;
            if (alt_drive != prev_alt) alt_flips++;
            prev_lp = line_pulse;
            prev_alt = alt_drive;
            if (dma_restart) break;
        end
        alt1 = alt_drive;
    endtask

    task automatic drive_cfg(input bit en, input bit on, input bit sp, input logic [1:0] dep,
                             input int w, input int h);
        @(posedge clk); #1;
        ctl_enable = en; ctl_disp_on = on; ctl_split = sp; ctl_depth = dep;
        panel_width = WW'(w); panel_height = HW'(h);
    endtask

    initial begin
        int lines, flips;
        bit a0, a1;
        repeat (4) @(negedge clk);
        chk({vdata, line_pulse, frame_pulse, alt_drive, dma_restart} == 8'h0,
            "reset outputs R9", int'({vdata, line_pulse, frame_pulse, alt_drive, dma_restart}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // colour, no split: 16 px -> 6 transfers
        drive_cfg(0, 0, 0, 2'b11, 16, 6);
        @(negedge clk);
        chk(rate_div == 10'd6, "rate colour R1", int'(rate_div), 6);
        drive_cfg(0, 0, 0, 2'b11, 32, 6);
        @(negedge clk);
        chk(rate_div == 10'd12, "rate colour 32 R1", int'(rate_div), 12);
        drive_cfg(0, 0, 1, 2'b11, 32, 6);
        @(negedge clk);
        chk(rate_div == 10'd8, "rate colour split R1", int'(rate_div), 8);
        drive_cfg(0, 0, 0, 2'b00, 32, 6);
        @(negedge clk);
        chk(rate_div == 10'd8, "rate mono R10", int'(rate_div), 8);
        drive_cfg(0, 0, 0, 2'b01, 32, 6);
        @(negedge clk);
        chk(rate_div == 10'd8, "rate grey2 R10", int'(rate_div), 8);
        drive_cfg(0, 0, 0, 2'b10, 32, 6);
        @(negedge clk);
        chk(rate_div == 10'd8, "rate grey4 R10", int'(rate_div), 8);

        // start scanning
        drive_cfg(1, 1, 0, 2'b11, 16, 6);
        @(posedge clk); @(negedge clk);
        chk(dma_restart && frame_pulse, "first start strobe R5", int'({dma_restart, frame_pulse}), 3);
        wait_dma();
        count_lines(lines, a0, a1, flips);
        chk(lines == 6, "lines per frame R2", lines, 6);
        chk(a0 != a1, "alt per frame R6", int'(a1), int'(!a0));

        // split: 3 lines per frame
        drive_cfg(1, 1, 1, 2'b11, 16, 6);
        wait_dma();
        count_lines(lines, a0, a1, flips);
        chk(lines == 3, "lines split R2", lines, 3);

        // per-line alternating drive
        @(posedge clk); #1 ctl_alt_line = 1'b1;
        wait_dma();
        count_lines(lines, a0, a1, flips);
        chk(flips == 3, "alt per line R6", flips, 3);
        @(posedge clk); #1 ctl_alt_line = 1'b0;

        // inversion with a fixed nibble
        @(posedge clk); #1 fix_val = 4'h5; fix_pix = 1'b1; ctl_invert = 1'b1;
        repeat (3) @(negedge clk);
        chk(vdata == 4'hA, "invert R8", int'(vdata), 10);
        @(posedge clk); #1 ctl_invert = 1'b0;
        repeat (2) @(negedge clk);
        chk(vdata == 4'h5, "pass-through R8", int'(vdata), 5);
        @(posedge clk); #1 fix_pix = 1'b0;

        // freeze mid-frame
        drive_cfg(1, 1, 0, 2'b11, 16, 6);
        wait_dma();
        repeat (10) @(negedge clk);
        @(posedge clk); #1 ctl_freeze = 1'b1;
        begin
            int starts;
            int lines_after;
            bit prev_lp;
            starts = 0; lines_after = 0; prev_lp = line_pulse;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (dma_restart) starts++;
                if (line_pulse && !prev_lp) lines_after++;
                prev_lp = line_pulse;
            end
            chk(starts == 0, "no start while frozen R7", starts, 0);
            chk(lines_after >= 4, "frame runs to its end R7", lines_after, 5);
            chk({line_pulse, frame_pulse, alt_drive, vdata} == 7'h0, "frozen quiet R7",
                int'({line_pulse, frame_pulse, alt_drive, vdata}), 0);
        end
        @(posedge clk); #1 ctl_freeze = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(dma_restart && frame_pulse, "restart after freeze R7", int'({dma_restart, frame_pulse}), 3);
        repeat (20) @(negedge clk);

        // display off
        @(posedge clk); #1 ctl_disp_on = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({vdata, line_pulse, frame_pulse, alt_drive, dma_restart} == 8'h0, "display off R9",
            int'({vdata, line_pulse, frame_pulse, alt_drive, dma_restart}), 0);
        @(posedge clk); #1 ctl_disp_on = 1'b1; ctl_enable = 1'b1;
        repeat (40) @(negedge clk);
        @(posedge clk); #1 ctl_enable = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({vdata, line_pulse, frame_pulse, alt_drive, dma_restart} == 8'h0, "enable off R9",
            int'({vdata, line_pulse, frame_pulse, alt_drive, dma_restart}), 0);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule